// File: doc/BRIEF.md
# Programmable Triple Parallel Port

This block sits on a processor's byte-wide register bus. It presents three 8-bit ports, A, B and C. A single control register sets each port's direction and operating mode. In simple mode, output writes are held in latches and drive the pins, while input reads return the live pin levels. In strobed mode, ports A and B latch input data on an external strobe, or announce output data and wait for an acknowledge. The handshake, flag and interrupt lines for this mode are taken from port C. Port A also has a bidirectional mode that combines both handshakes on one port.

A control write with bit 7 clear does not change the mode. Instead, it forces one bit of port C to a chosen value. The same command sets and clears the interrupt enables that live at the strobe and acknowledge positions of port C. Each pad is modelled as three separate vectors: a pin input, a latched output and an output enable. Bus accesses are synchronous. Every clock cycle in which chip select and a strobe are both low counts as one access.

Top module: `pport_triple`

## Requirements
- R1: After reset, every output enable is 0, every output latch is 0, and the control register reads 8'h9B.
- R2: Reads and writes take effect only while cs_n is low. When no read is active, rdata is 0. The register select values are 0 for A, 1 for B, 2 for C and 3 for control.
- R3: A control write with bit 7 set is a mode word. Bit 4 sets A's direction, bit 1 sets B's, bit 3 sets C[7:4] and bit 0 sets C[3:0], with 1 meaning input. Bits 6:5 set A's mode and bit 2 sets B's mode. For example, 8'h82 makes A and C outputs and B an input.
- R4: In simple mode, a write to an output port appears on its pins. A read of an output port returns the latch. A read of an input port returns the current pin level.
- R5: A control write with bit 7 clear writes bit 0 into port C bit [3:1]. For example, 8'h0D sets C6. The mode word is left unchanged.
- R6: Every mode-word write clears all output latches, port C included, and all handshake flags.
- R7: In strobed input, a falling edge on the strobe latches the pins and sets a buffer-full flag. For A, the strobe is C4 and the flag is C5. For B, the strobe is C2 and the flag is C1. The interrupt line (C3 for A, C0 for B) rises only if the enable is set (C4 for A, C2 for B). A read of the port returns the latched byte and clears both the flag and the interrupt.
- R8: In strobed output, a write drives the active-low full line low. For A this line is C7; for B it is C1. An acknowledge falling edge (C6 for A, C2 for B) drives the line high again. After that, the interrupt rises if the enable is set (C6 for A, C2 for B). The next write clears the interrupt.
- R9: Bit 6 of the mode word selects bidirectional mode for A, and bits 5:3 are then ignored. A drives its pins only while C6 is low. It accepts strobed input on C4 and sets C7, C5 and C3 as in R7 and R8. 8'hC4 also puts B in strobed output.
- R10: In strobed modes, a read of port C returns status at the reassigned bits. The flag and interrupt positions return their pin levels. The strobe and acknowledge positions return the interrupt enable.
- R11: The port C bits that no handshake uses follow the direction of their half. Output bits drive the latch, read back the latch, and are enabled. Input bits read the pin. Handshake outputs are always enabled, and strobe and acknowledge inputs are never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read is active |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C pin drive values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The assertions assume several things about the inputs. Each bus access lasts one cycle with only one strobe low. The strobe and acknowledge pins idle high and fall only as separate one-cycle pulses. No strobe and no processor access to the same port arrive in the same cycle. The stimulus keeps within these limits. Every access comes from a task that lowers the strobe for one cycle, changes inputs only at falling clock edges, and releases port C handshake pins to all-ones between pulses. Random data and random simple-mode words exercise only fields the requirements define.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int PORT_W     = 8;
    localparam int SEL_W      = 2;
    localparam logic [SEL_W-1:0] SEL_A    = 2'd0;
    localparam logic [SEL_W-1:0] SEL_B    = 2'd1;
    localparam logic [SEL_W-1:0] SEL_C    = 2'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd3;
    localparam logic [PORT_W-1:0] CTRL_RESET = 8'h9B;

    // Port C positions used by the strobed modes
    localparam int PC_INTR_B = 0;
    localparam int PC_FLAG_B = 1;
    localparam int PC_HS_B   = 2;
    localparam int PC_INTR_A = 3;
    localparam int PC_STB_A  = 4;
    localparam int PC_IBF_A  = 5;
    localparam int PC_ACK_A  = 6;
    localparam int PC_OBF_A  = 7;

    typedef enum logic [1:0] {GM_SIMPLE, GM_STROBED, GM_BIDIR} grp_mode_e;

    typedef struct packed {
        grp_mode_e a_mode;
        logic      a_in;
        logic      pcu_in;
        logic      b_strobed;
        logic      b_in;
        logic      pcl_in;
    } cfg_t;

    function automatic cfg_t decode_cfg(input logic [PORT_W-1:0] w);
        cfg_t c;
        c.a_mode    = w[6] ? GM_BIDIR : (w[5] ? GM_STROBED : GM_SIMPLE);
        c.a_in      = w[4];
        c.pcu_in    = w[3];
        c.b_strobed = w[2];
        c.b_in      = w[1];
        c.pcl_in    = w[0];
        return c;
    endfunction
endpackage

// File: rtl/pport_hs_chan.sv
module pport_hs_chan
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              in_en,
    input  logic              out_en,
    input  logic              stb_n,
    input  logic              ack_n,
    input  logic              inte_in,
    input  logic              inte_out,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [PORT_W-1:0] pins,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] in_q,
    output logic [PORT_W-1:0] out_q,
    output logic              ibf,
    output logic              obf,
    output logic              intr
);
    logic stb_q, ack_q, done;
    logic stb_fall, ack_fall;

    assign stb_fall = stb_q & ~stb_n;
    assign ack_fall = ack_q & ~ack_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b1;
            ack_q <= 1'b1;
        end else begin
            stb_q <= stb_n;
            ack_q <= ack_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            in_q  <= '0;
            out_q <= '0;
            ibf   <= 1'b0;
            obf   <= 1'b0;
            done  <= 1'b0;
        end else begin
            if (stb_fall && in_en) begin
                in_q <= pins;
                ibf  <= 1'b1;
            end else if (cpu_rd && in_en) begin
                ibf  <= 1'b0;
            end
            if (cpu_wr) out_q <= wdata;
            if (cpu_wr && out_en)        obf <= 1'b1;
            else if (ack_fall && out_en) obf <= 1'b0;
            if (cpu_wr)                         done <= 1'b0;
            else if (ack_fall && out_en && obf) done <= 1'b1;
        end
    end

    assign intr = (in_en & inte_in & ibf) | (out_en & inte_out & done);

    a_r7_flag_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (stb_fall && in_en && !clr) |=> ibf);
    a_r8_full_off_on_ack: assert property (@(posedge clk) disable iff (rst)
        (ack_fall && out_en && !cpu_wr && !clr) |=> !obf);
    a_r6_clear_on_mode: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!ibf && !obf && !intr && out_q == '0));
endmodule

// File: rtl/pport_c_mux.sv
module pport_c_mux
    import pport_pkg::*;
(
    input  cfg_t              cfg,
    input  logic [PORT_W-1:0] pc_latch,
    input  logic [PORT_W-1:0] pc_in,
    input  logic              ibf_a,
    input  logic              obf_a,
    input  logic              intr_a,
    input  logic              ibf_b,
    input  logic              obf_b,
    input  logic              intr_b,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe,
    output logic [PORT_W-1:0] pc_rd
);
    localparam int HALF = PORT_W / 2;
    logic a_strobed, a_in_side, a_out_side;
    logic [PORT_W-1:0] plain_oe;

    assign a_strobed  = (cfg.a_mode != GM_SIMPLE);
    assign a_in_side  = (cfg.a_mode == GM_BIDIR) || (cfg.a_mode == GM_STROBED && cfg.a_in);
    assign a_out_side = (cfg.a_mode == GM_BIDIR) || (cfg.a_mode == GM_STROBED && !cfg.a_in);
    assign plain_oe   = {{HALF{~cfg.pcu_in}}, {HALF{~cfg.pcl_in}}};

    always_comb begin
        pc_out = pc_latch;
        pc_oe  = plain_oe;
        pc_rd  = (pc_latch & plain_oe) | (pc_in & ~plain_oe);
        if (a_strobed) begin
            pc_out[PC_INTR_A] = intr_a;
            pc_oe[PC_INTR_A]  = 1'b1;
            pc_rd[PC_INTR_A]  = intr_a;
        end
        if (a_in_side) begin
            pc_oe[PC_STB_A]  = 1'b0;
            pc_rd[PC_STB_A]  = pc_latch[PC_STB_A];
            pc_out[PC_IBF_A] = ibf_a;
            pc_oe[PC_IBF_A]  = 1'b1;
            pc_rd[PC_IBF_A]  = ibf_a;
        end
        if (a_out_side) begin
            pc_oe[PC_ACK_A]  = 1'b0;
            pc_rd[PC_ACK_A]  = pc_latch[PC_ACK_A];
            pc_out[PC_OBF_A] = ~obf_a;
            pc_oe[PC_OBF_A]  = 1'b1;
            pc_rd[PC_OBF_A]  = ~obf_a;
        end
        if (cfg.b_strobed) begin
            pc_oe[PC_HS_B]    = 1'b0;
            pc_rd[PC_HS_B]    = pc_latch[PC_HS_B];
            pc_out[PC_FLAG_B] = cfg.b_in ? ibf_b : ~obf_b;
            pc_oe[PC_FLAG_B]  = 1'b1;
            pc_rd[PC_FLAG_B]  = cfg.b_in ? ibf_b : ~obf_b;
            pc_out[PC_INTR_B] = intr_b;
            pc_oe[PC_INTR_B]  = 1'b1;
            pc_rd[PC_INTR_B]  = intr_b;
        end
    end
endmodule

// File: rtl/pport_triple.sv
module pport_triple
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);
    logic [PORT_W-1:0] ctrl, pc_latch, pc_rd;
    logic [PORT_W-1:0] a_inq, b_inq;
    logic wr_act, rd_act, mode_wr, bsr_wr;
    logic a_ien, a_oen, b_ien, b_oen;
    logic ibf_a, obf_a, intr_a, ibf_b, obf_b, intr_b;
    cfg_t cfg;

    assign cfg     = decode_cfg(ctrl);
    assign wr_act  = ~cs_n & ~wr_n;
    assign rd_act  = ~cs_n & ~rd_n & wr_n;
    assign mode_wr = wr_act && sel == SEL_CTRL && wdata[7];
    assign bsr_wr  = wr_act && sel == SEL_CTRL && !wdata[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= CTRL_RESET;
            pc_latch <= '0;
        end else if (mode_wr) begin
            ctrl     <= wdata;
            pc_latch <= '0;
        end else if (bsr_wr) begin
            pc_latch[wdata[3:1]] <= wdata[0];
        end else if (wr_act && sel == SEL_C) begin
            pc_latch <= wdata;
        end
    end

    assign a_ien = (cfg.a_mode == GM_BIDIR) || (cfg.a_mode == GM_STROBED && cfg.a_in);
    assign a_oen = (cfg.a_mode == GM_BIDIR) || (cfg.a_mode == GM_STROBED && !cfg.a_in);
    assign b_ien = cfg.b_strobed & cfg.b_in;
    assign b_oen = cfg.b_strobed & ~cfg.b_in;

    pport_hs_chan u_chan_a (
        .clk(clk), .rst(rst), .clr(mode_wr), .in_en(a_ien), .out_en(a_oen),
        .stb_n(pc_in[PC_STB_A]), .ack_n(pc_in[PC_ACK_A]),
        .inte_in(pc_latch[PC_STB_A]), .inte_out(pc_latch[PC_ACK_A]),
        .cpu_wr(wr_act && sel == SEL_A), .cpu_rd(rd_act && sel == SEL_A),
        .pins(pa_in), .wdata(wdata), .in_q(a_inq), .out_q(pa_out),
        .ibf(ibf_a), .obf(obf_a), .intr(intr_a));

    pport_hs_chan u_chan_b (
        .clk(clk), .rst(rst), .clr(mode_wr), .in_en(b_ien), .out_en(b_oen),
        .stb_n(pc_in[PC_HS_B]), .ack_n(pc_in[PC_HS_B]),
        .inte_in(pc_latch[PC_HS_B]), .inte_out(pc_latch[PC_HS_B]),
        .cpu_wr(wr_act && sel == SEL_B), .cpu_rd(rd_act && sel == SEL_B),
        .pins(pb_in), .wdata(wdata), .in_q(b_inq), .out_q(pb_out),
        .ibf(ibf_b), .obf(obf_b), .intr(intr_b));

    pport_c_mux u_cmux (
        .cfg(cfg), .pc_latch(pc_latch), .pc_in(pc_in),
        .ibf_a(ibf_a), .obf_a(obf_a), .intr_a(intr_a),
        .ibf_b(ibf_b), .obf_b(obf_b), .intr_b(intr_b),
        .pc_out(pc_out), .pc_oe(pc_oe), .pc_rd(pc_rd));

    always_comb begin
        if (cfg.a_mode == GM_BIDIR) pa_oe = {PORT_W{~pc_in[PC_ACK_A]}};
        else                        pa_oe = {PORT_W{~cfg.a_in}};
    end
    assign pb_oe = {PORT_W{~cfg.b_in}};

    always_comb begin
        rdata = '0;
        if (rd_act) begin
            unique case (sel)
                SEL_A:   rdata = a_ien ? a_inq : (cfg.a_in && cfg.a_mode == GM_SIMPLE) ? pa_in : pa_out;
                SEL_B:   rdata = b_ien ? b_inq : (cfg.b_in && !cfg.b_strobed) ? pb_in : pb_out;
                SEL_C:   rdata = pc_rd;
                default: rdata = ctrl;
            endcase
        end
    end

    a_r5_bit_command: assert property (@(posedge clk) disable iff (rst)
        bsr_wr |=> (pc_latch[$past(wdata[3:1])] == $past(wdata[0]) && ctrl == $past(ctrl)));
    a_r2_idle_bus: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(ctrl) && $stable(pc_latch)));
    a_r9_bidir_release: assert property (@(posedge clk) disable iff (rst)
        (cfg.a_mode == GM_BIDIR && pc_in[PC_ACK_A]) |-> pa_oe == '0);
    a_r2_quiet_rdata: assert property (@(posedge clk) disable iff (rst)
        !rd_act |-> rdata == '0);
endmodule

// File: tb/tb_pport_triple.sv
module tb_pport_triple;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] sel = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pport_triple dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .sel(sel),
        .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
        .pc_out(pc_out), .pc_oe(pc_oe));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [23:0] exp_oe_simple(input logic [7:0] w);
        return {w[4] ? 8'h00 : 8'hFF, w[1] ? 8'h00 : 8'hFF, {4{~w[3]}}, {4{~w[0]}}};
    endfunction

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d, input logic use_cs = 1'b1);
        @(negedge clk);
        sel = s; wdata = d; wr_n = 1'b0; cs_n = ~use_cs;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        sel = s; rd_n = 1'b0; cs_n = 1'b0;
        #5 d = rdata;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic pulse_c(input int b);
        @(negedge clk);
        pc_in[b] = 1'b0;
        @(negedge clk);
        pc_in[b] = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, d, w;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", {pa_oe, pb_oe, pc_oe}, 24'h0);
        check("R1 latches", {pa_out, pb_out, pc_out}, 24'h0);
        bus_rd(2'd3, r); check("R1 ctrl", r, 8'h9B);
        // R3 example word
        bus_wr(2'd3, 8'h82);
        check("R3 0x82 oe", {pa_oe, pb_oe, pc_oe}, 24'hFF00FF);
        // R2 chip select gating
        bus_wr(2'd0, 8'h11, 1'b0);
        bus_rd(2'd0, r); check("R2 no-cs write ignored", r, 8'h00);
        @(negedge clk); sel = 2'd3; rd_n = 1'b0; #5 check("R2 no-cs rdata", rdata, 8'h00);
        @(negedge clk); rd_n = 1'b1;
        // R4 random simple-mode traffic
        for (int i = 0; i < 8; i++) begin
            d = 8'($urandom); bus_wr(2'd0, d);
            check("R4 pa pins", pa_out, d);
            bus_rd(2'd0, r); check("R4 pa readback", r, d);
            pb_in = 8'($urandom); bus_rd(2'd1, r); check("R4 pb live", r, pb_in);
        end
        // R3 random mode words
        for (int i = 0; i < 8; i++) begin
            w = 8'h80 | (8'($urandom) & 8'h1B);
            bus_wr(2'd3, w);
            check("R3 oe", {pa_oe, pb_oe, pc_oe}, exp_oe_simple(w));
        end
        // R5 bit command
        bus_wr(2'd3, 8'h82);
        bus_wr(2'd3, 8'h0D); check("R5 set C6", pc_out, 8'h40);
        bus_rd(2'd3, r); check("R5 ctrl kept", r, 8'h82);
        bus_wr(2'd3, 8'h0C); check("R5 clear C6", pc_out, 8'h00);
        // R6 mode write clears latches
        bus_wr(2'd0, 8'h5A); bus_wr(2'd2, 8'h33);
        bus_wr(2'd3, 8'h82);
        check("R6 cleared", {pa_out, pc_out}, 16'h0);
        // R11 split port C
        bus_wr(2'd3, 8'h88); check("R11 oe", pc_oe, 8'h0F);
        bus_wr(2'd2, 8'h06); pc_in = 8'h3F;
        bus_rd(2'd2, r); check("R11 read", r, 8'h36);
        pc_in = 8'hFF;
        // R7 port A strobed input
        bus_wr(2'd3, 8'hB0); check("R11 A-in roles", pc_oe, 8'hEF);
        bus_wr(2'd3, 8'h09);
        pa_in = 8'hC3; pulse_c(4); pa_in = 8'h00;
        check("R7 A flag+intr", {pc_out[5], pc_out[3]}, 2'b11);
        bus_rd(2'd2, r); check("R10 A-in status", r, 8'h38);
        bus_rd(2'd0, r); check("R7 A latched", r, 8'hC3);
        check("R7 A cleared", {pc_out[5], pc_out[3]}, 2'b00);
        bus_wr(2'd3, 8'h08);
        pa_in = 8'h77; pulse_c(4);
        check("R7 A no inte", {pc_out[5], pc_out[3]}, 2'b10);
        bus_rd(2'd0, r); check("R7 A data2", r, 8'h77);
        // R7 port B strobed input
        bus_wr(2'd3, 8'h86); bus_wr(2'd3, 8'h05);
        pb_in = 8'h9E; pulse_c(2); pb_in = 8'h00;
        check("R7 B flag+intr", pc_out[1:0], 2'b11);
        bus_rd(2'd1, r); check("R7 B latched", r, 8'h9E);
        check("R7 B cleared", pc_out[1:0], 2'b00);
        // R8 port A strobed output
        bus_wr(2'd3, 8'hA0); bus_wr(2'd3, 8'h0D);
        bus_wr(2'd0, 8'h4B);
        check("R8 A data", pa_out, 8'h4B);
        check("R8 A full low", {pc_out[7], pc_out[3]}, 2'b00);
        bus_rd(2'd2, r); check("R10 A-out status", r, 8'h40);
        pulse_c(6);
        check("R8 A ack", {pc_out[7], pc_out[3]}, 2'b11);
        bus_wr(2'd0, 8'h11);
        check("R8 A rewrite", {pc_out[7], pc_out[3]}, 2'b00);
        // R9 bidirectional
        bus_wr(2'd3, 8'hC4);
        check("R9 C roles", pc_oe, 8'hAB);
        check("R9 A idle", pa_oe, 8'h00);
        bus_wr(2'd0, 8'h6D);
        check("R9 full low", {pa_out, pc_out[7]}, 9'h0DA);
        @(negedge clk); pc_in[6] = 1'b0; #1 check("R9 drive on ack", pa_oe, 8'hFF);
        @(negedge clk); pc_in[6] = 1'b1; #1 check("R9 release", pa_oe, 8'h00);
        check("R9 full cleared", pc_out[7], 1'b1);
        pa_in = 8'h2C; pulse_c(4);
        bus_rd(2'd2, r); check("R10 bidir status", r, 8'hA2);
        bus_rd(2'd0, r); check("R9 in data", r, 8'h2C);
        bus_wr(2'd1, 8'h5E);
        check("R9 B out full", {pb_out, pc_out[1], pb_oe}, {8'h5E, 1'b0, 8'hFF});
        bus_wr(2'd3, 8'hFC); check("R9 bits 5:3 ignored", pc_oe, 8'hAB);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule